// File: doc/BRIEF.md
# Programmable Event Counter Unit

This block is a small performance-monitoring unit holding a parameterized number of general-purpose event counters (four by default). Each counter owns an event-selection register that names one event line, a unit mask that is intersected with that line's qualifier bits, a user-level-only filter and a local enable. A single global control register carries one enable bit per counter. A counter advances only when both its global bit and its local enable are set, so software can start or stop a group of counters with one write.

Software configures and inspects the unit through a register port that takes one single-cycle read or write strobe per cycle with an address and 64-bit write data. Read data and an error strobe come back one cycle later. The port has no back-pressure: every strobe is accepted in the cycle it is presented. A second read path lets running code fetch a counter by index as a low and a high 32-bit half. At user level this path is allowed only when a user-read-allow input is high; otherwise the request is answered with a fault flag.

Events arrive as a vector of pulses, one per event line, each with an 8-bit qualifier. The current privilege level is an input.

Top module: `pmu_event_counter_unit`

## Requirements
- R1: After reset every counter and every event-selection register reads 0, and the global control register reads 0x0000_0007_0000_000F.
- R2: A counter increments by one in a cycle only when its global control bit (bit i for counter i) and the enable flag (bit 22) of its event-selection register are both 1. If either is 0 it holds its value.
- R3: A counter with event code C (event-selection bits 7:0) and unit mask M (bits 15:8) counts a cycle only when pulse line C is high and that line's qualifier ANDed with M is nonzero. A code at or above the number of event lines never counts.
- R4: With the user-only flag (bit 16) set, events count only while the privilege level is 3. With it clear, events count at every level.
- R5: Event-selection register i is at address 0x186+i, counter i is at 0x0C1+i and global control is at 0x38F. Read data appears on the cycle after the read strobe.
- R6: A register write to counter i loads bits 47:0 of the write data. A write takes priority over an event counted in the same cycle.
- R7: Counters are 48 bits wide and wrap from 0xFFFF_FFFF_FFFF to 0.
- R8: Global control keeps only bits 3:0 (counters) and 34:32 (fixed-counter enables). Event-selection keeps only bits 7:0, 15:8, 16 and 22. All other bits are dropped on write and read back 0.
- R9: A read or write to an address that maps to no register raises the error strobe for one cycle on the next cycle. A read there returns 0, and a write there changes nothing.
- R10: A privileged read request with index i answers on the next cycle with rd_valid high, rd_lo = counter bits 31:0 and rd_hi = counter bits 47:32 zero-extended. At privilege level 3 with user-read-allow low it instead answers with rd_fault high and both halves 0. Levels 0 to 2 are always allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 64 | One pulse bit per event line |
| evt_qual | input | 512 | 8-bit qualifier per event line, line k at bits 8k+7:8k |
| priv_lvl | input | 2 | Current privilege level (0..3) |
| usr_rd_allow | input | 1 | Allows the counter read path at level 3 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, one cycle after the read strobe |
| reg_err | output | 1 | Unmapped-access strobe |
| rd_req | input | 1 | Counter read-path request |
| rd_idx | input | 2 | Counter index for the read path |
| rd_valid | output | 1 | Read-path answer strobe |
| rd_lo | output | 32 | Counter bits 31:0 |
| rd_hi | output | 32 | Counter bits 47:32, zero-extended |
| rd_fault | output | 1 | Read-path request rejected |

## Verification
Directed pulse trains are aimed at one event line. They vary the qualifier (intersecting and disjoint with the mask), the line (selected and neighbouring), the privilege level (0 and 3) and the two enables, so a lost AND term in the counting condition shows up as a wrong count. Constrained random rounds drive dense random pulses, qualifiers and levels against random configurations that include an out-of-range code. These rounds separate per-counter selection and mask decoding from the shared enables. Boundary patterns cover the 48-bit wrap, a write colliding with an event, masked-off register bits, unmapped addresses and the faulting and permitted read-path cases.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 64;

  typedef struct packed {
    logic       en;
    logic       usr;
    logic [7:0] umask;
    logic [7:0] code;
  } evsel_t;

  function automatic logic [DATA_W-1:0] evsel_to_word(evsel_t s);
    return {41'b0, s.en, 5'b0, s.usr, s.umask, s.code};
  endfunction

  function automatic evsel_t word_to_evsel(logic [DATA_W-1:0] w);
    evsel_t s;
    s.code  = w[7:0];
    s.umask = w[15:8];
    s.usr   = w[16];
    s.en    = w[22];
    return s;
  endfunction
endpackage

// File: rtl/pmu_evt_match.sv
module pmu_evt_match
  import pmu_pkg::*;
#(
  parameter int unsigned EVT_LINES = 64
) (
  input  evsel_t                   sel,
  input  logic [EVT_LINES-1:0]     evt_pulse,
  input  logic [EVT_LINES*8-1:0]   evt_qual,
  input  logic [1:0]               priv_lvl,
  output logic                     hit
);
  localparam int unsigned IDX_W = (EVT_LINES > 1) ? $clog2(EVT_LINES) : 1;

  logic [IDX_W-1:0] line;
  logic             in_range;
  logic             pulse;
  logic [7:0]       qual;
  logic             priv_ok;

  always_comb begin
    line     = sel.code[IDX_W-1:0];
    in_range = (int'(sel.code) < int'(EVT_LINES));
    pulse    = evt_pulse[line];
    qual     = evt_qual[int'(line)*8 +: 8];
    priv_ok  = !sel.usr || (priv_lvl == 2'd3);
    hit      = in_range && pulse && (|(qual & sel.umask)) && priv_ok;
  end
endmodule

// File: rtl/pmu_ctr_slice.sv
module pmu_ctr_slice
  import pmu_pkg::*;
#(
  parameter int unsigned CTR_W     = 48,
  parameter int unsigned EVT_LINES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   glob_en,
  input  logic                   sel_wr,
  input  logic                   cnt_wr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [EVT_LINES-1:0]   evt_pulse,
  input  logic [EVT_LINES*8-1:0] evt_qual,
  input  logic [1:0]             priv_lvl,
  output evsel_t                 sel_q,
  output logic [CTR_W-1:0]       cnt_q
);
  logic hit;
  logic inc;

  pmu_evt_match #(.EVT_LINES(EVT_LINES)) u_match (
    .sel       (sel_q),
    .evt_pulse (evt_pulse),
    .evt_qual  (evt_qual),
    .priv_lvl  (priv_lvl),
    .hit       (hit)
  );

  assign inc = glob_en && sel_q.en && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_wr) begin
      sel_q <= word_to_evsel(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      cnt_q <= wdata[CTR_W-1:0];
    end else if (inc) begin
      cnt_q <= cnt_q + CTR_W'(1);
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !(glob_en && sel_q.en)) |=> $stable(cnt_q)); // R2
  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CTR_W'(1))); // R2
  AST_USR_ONLY_LEVEL3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel_q.usr) |-> (priv_lvl == 2'd3)); // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wdata[CTR_W-1:0]))); // R6
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && inc && cnt_q == '1) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/pmu_access.sv
module pmu_access
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CTR    = 4,
  parameter int unsigned NUM_FIX    = 3,
  parameter int unsigned CTR_W      = 48,
  parameter int unsigned SEL_BASE   = 'h186,
  parameter int unsigned CNT_BASE   = 'h0C1,
  parameter int unsigned GCTRL_ADDR = 'h38F,
  localparam int unsigned IDX_W     = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_err,
  input  logic [1:0]         priv_lvl,
  input  logic               usr_rd_allow,
  input  logic               rd_req,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [31:0]        rd_lo,
  output logic [31:0]        rd_hi,
  output logic               rd_fault,
  input  evsel_t             sel_q [NUM_CTR],
  input  logic [CTR_W-1:0]   cnt_q [NUM_CTR],
  output logic [NUM_CTR-1:0] sel_wr,
  output logic [NUM_CTR-1:0] cnt_wr,
  output logic [NUM_CTR-1:0] glob_en
);
  localparam logic [DATA_W-1:0] GMASK =
    (((DATA_W'(1) << NUM_FIX) - DATA_W'(1)) << 32) | ((DATA_W'(1) << NUM_CTR) - DATA_W'(1));

  logic [DATA_W-1:0] gctrl_q;
  logic [DATA_W-1:0] rd_val;
  logic              mapped;
  logic              g_wr;
  logic              deny;
  logic [CTR_W-1:0]  sel_cnt;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
    assign sel_wr[i]  = reg_wr && (reg_addr == ADDR_W'(SEL_BASE + i));
    assign cnt_wr[i]  = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + i));
    assign glob_en[i] = gctrl_q[i];
  end

  assign g_wr = reg_wr && (reg_addr == ADDR_W'(GCTRL_ADDR));

  always_comb begin
    rd_val = '0;
    mapped = (reg_addr == ADDR_W'(GCTRL_ADDR));
    if (mapped) rd_val = gctrl_q;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == ADDR_W'(CNT_BASE + i)) begin
        mapped = 1'b1;
        rd_val = DATA_W'(cnt_q[i]);
      end
      if (reg_addr == ADDR_W'(SEL_BASE + i)) begin
        mapped = 1'b1;
        rd_val = evsel_to_word(sel_q[i]);
      end
    end
  end

  always_comb begin
    deny    = (priv_lvl == 2'd3) && !usr_rd_allow;
    sel_cnt = '0;
    if (int'(rd_idx) < int'(NUM_CTR)) sel_cnt = cnt_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctrl_q <= GMASK;
    end else if (g_wr) begin
      gctrl_q <= reg_wdata & GMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_rdata <= reg_rd ? rd_val : '0;
      reg_err   <= (reg_rd || reg_wr) && !mapped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_fault <= 1'b0;
      rd_lo    <= '0;
      rd_hi    <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_fault <= rd_req && deny;
      rd_lo    <= (rd_req && !deny) ? sel_cnt[31:0] : '0;
      rd_hi    <= (rd_req && !deny) ? 32'(sel_cnt[CTR_W-1:32]) : '0;
    end
  end

  AST_GCTRL_ONLY_IMPL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (gctrl_q & ~GMASK) == '0); // R8
  AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_err && !reg_rd && !reg_wr) |=> !reg_err); // R9
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !mapped) |=> (reg_rdata == '0 && reg_err)); // R9
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> (rd_valid && rd_lo == '0 && rd_hi == '0)); // R10
  AST_ANSWER_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R10
endmodule

// File: rtl/pmu_event_counter_unit.sv
module pmu_event_counter_unit
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CTR    = 4,
  parameter int unsigned NUM_FIX    = 3,
  parameter int unsigned CTR_W      = 48,
  parameter int unsigned EVT_LINES  = 64,
  parameter int unsigned SEL_BASE   = 'h186,
  parameter int unsigned CNT_BASE   = 'h0C1,
  parameter int unsigned GCTRL_ADDR = 'h38F,
  localparam int unsigned IDX_W     = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EVT_LINES-1:0]   evt_pulse,
  input  logic [EVT_LINES*8-1:0] evt_qual,
  input  logic [1:0]             priv_lvl,
  input  logic                   usr_rd_allow,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [11:0]            reg_addr,
  input  logic [63:0]            reg_wdata,
  output logic [63:0]            reg_rdata,
  output logic                   reg_err,
  input  logic                   rd_req,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic                   rd_valid,
  output logic [31:0]            rd_lo,
  output logic [31:0]            rd_hi,
  output logic                   rd_fault
);
  evsel_t             sel_q [NUM_CTR];
  logic [CTR_W-1:0]   cnt_q [NUM_CTR];
  logic [NUM_CTR-1:0] sel_wr;
  logic [NUM_CTR-1:0] cnt_wr;
  logic [NUM_CTR-1:0] glob_en;

  pmu_access #(
    .NUM_CTR(NUM_CTR), .NUM_FIX(NUM_FIX), .CTR_W(CTR_W),
    .SEL_BASE(SEL_BASE), .CNT_BASE(CNT_BASE), .GCTRL_ADDR(GCTRL_ADDR)
  ) u_access (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .reg_err      (reg_err),
    .priv_lvl     (priv_lvl),
    .usr_rd_allow (usr_rd_allow),
    .rd_req       (rd_req),
    .rd_idx       (rd_idx),
    .rd_valid     (rd_valid),
    .rd_lo        (rd_lo),
    .rd_hi        (rd_hi),
    .rd_fault     (rd_fault),
    .sel_q        (sel_q),
    .cnt_q        (cnt_q),
    .sel_wr       (sel_wr),
    .cnt_wr       (cnt_wr),
    .glob_en      (glob_en)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    pmu_ctr_slice #(.CTR_W(CTR_W), .EVT_LINES(EVT_LINES)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .glob_en   (glob_en[i]),
      .sel_wr    (sel_wr[i]),
      .cnt_wr    (cnt_wr[i]),
      .wdata     (reg_wdata),
      .evt_pulse (evt_pulse),
      .evt_qual  (evt_qual),
      .priv_lvl  (priv_lvl),
      .sel_q     (sel_q[i]),
      .cnt_q     (cnt_q[i])
    );
  end
endmodule

// File: tb/sim_pmu_event_counter_unit.sv
module sim_pmu_event_counter_unit;
  localparam int NC = 4;
  localparam int NL = 64;
  localparam logic [63:0] G_RST   = 64'h0000_0007_0000_000F;
  localparam logic [63:0] SEL_MSK = 64'h0000_0000_0041_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] evt_pulse = '0;
  logic [NL*8-1:0] evt_qual = '0;
  logic [1:0] priv_lvl = 2'd0;
  logic usr_rd_allow = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic reg_err;
  logic rd_req = 1'b0;
  logic [1:0] rd_idx = '0;
  logic rd_valid, rd_fault;
  logic [31:0] rd_lo, rd_hi;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pmu_event_counter_unit u0 (.*);

  // reference state, updated from the requirements
  logic [63:0] m_sel [NC];
  logic [47:0] m_cnt [NC];
  logic [63:0] m_g;

  function automatic logic f_hit(logic [63:0] s, logic [NL-1:0] p, logic [NL*8-1:0] q, logic [1:0] pl);
    int c = int'(s[7:0]);
    if (c >= NL) return 1'b0;
    if (!p[c]) return 1'b0;
    if ((q[c*8 +: 8] & s[15:8]) == 8'h00) return 1'b0;
    if (s[16] && pl != 2'd3) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin m_sel[i] <= '0; m_cnt[i] <= '0; end
      m_g <= G_RST;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (reg_wr && reg_addr == 12'(12'h0C1 + i)) m_cnt[i] <= reg_wdata[47:0];
        else if (m_g[i] && m_sel[i][22] && f_hit(m_sel[i], evt_pulse, evt_qual, priv_lvl))
          m_cnt[i] <= m_cnt[i] + 48'd1;
        if (reg_wr && reg_addr == 12'(12'h186 + i)) m_sel[i] <= reg_wdata & SEL_MSK;
      end
      if (reg_wr && reg_addr == 12'h38F) m_g <= reg_wdata & G_RST;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d, output logic e);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata; e = reg_err;
  endtask

  task automatic prd(input int idx, output logic [31:0] lo, output logic [31:0] hi,
                     output logic f, output logic v);
    @(negedge clk); rd_req = 1'b1; rd_idx = 2'(idx);
    @(negedge clk); rd_req = 1'b0; lo = rd_lo; hi = rd_hi; f = rd_fault; v = rd_valid;
  endtask

  task automatic pulses(input int line, input logic [7:0] q, input logic [1:0] pl, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      priv_lvl = pl; evt_pulse = '0; evt_pulse[line] = 1'b1; evt_qual = '0; evt_qual[line*8 +: 8] = q;
    end
    @(negedge clk); evt_pulse = '0; evt_qual = '0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d; logic e; logic [31:0] lo, hi; logic f, v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(12'h38F, d, e); chk(d, G_RST, "R1 global reset");
    rd(12'h0C1, d, e); chk(d, 64'd0, "R1 counter0 reset");
    rd(12'h189, d, e); chk(d, 64'd0, "R1 evsel3 reset");

    // R3 R4 R5 basic counting on line 0x24 with user-only flag
    wr(12'h186, 64'h0041_3F24);
    wr(12'h0C1, 64'd0);
    pulses(8'h24, 8'h01, 2'd3, 5);
    rd(12'h0C1, d, e); chk(d, 64'd5, "R3 matching pulses counted");
    pulses(8'h24, 8'h01, 2'd0, 4);
    rd(12'h0C1, d, e); chk(d, 64'd5, "R4 level0 ignored with user flag");
    pulses(8'h24, 8'h40, 2'd3, 4);
    rd(12'h0C1, d, e); chk(d, 64'd5, "R3 disjoint qualifier ignored");
    pulses(8'h25, 8'hFF, 2'd3, 4);
    rd(12'h0C1, d, e); chk(d, 64'd5, "R3 other line ignored");

    // R2 enables
    wr(12'h38F, 64'h0000_0007_0000_000E);
    pulses(8'h24, 8'h01, 2'd3, 3);
    rd(12'h0C1, d, e); chk(d, 64'd5, "R2 global bit clear holds");
    wr(12'h38F, G_RST);
    wr(12'h186, 64'h0001_3F24);
    pulses(8'h24, 8'h01, 2'd3, 3);
    rd(12'h0C1, d, e); chk(d, 64'd5, "R2 local enable clear holds");

    // R4 no user flag counts at level 0
    wr(12'h186, 64'h0040_3F24);
    pulses(8'h24, 8'h20, 2'd0, 2);
    rd(12'h0C1, d, e); chk(d, 64'd7, "R4 counts at level0 without flag");

    // R6 R7 load and wrap
    wr(12'h0C1, 64'hABCD_FFFF_FFFF_FFFF);
    rd(12'h0C1, d, e); chk(d, 64'h0000_FFFF_FFFF_FFFF, "R6 load low 48 bits");
    pulses(8'h24, 8'h01, 2'd0, 1);
    rd(12'h0C1, d, e); chk(d, 64'd0, "R7 wrap to zero");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h0C1; reg_wdata = 64'd100;
    evt_pulse[8'h24] = 1'b1; evt_qual[8'h24*8 +: 8] = 8'h01;
    @(negedge clk); reg_wr = 1'b0; evt_pulse = '0; evt_qual = '0;
    rd(12'h0C1, d, e); chk(d, 64'd100, "R6 write wins over event");

    // R8 implemented bits
    wr(12'h38F, '1);
    rd(12'h38F, d, e); chk(d, G_RST, "R8 global keeps bits 3:0 and 34:32");
    wr(12'h188, '1);
    rd(12'h188, d, e); chk(d, 64'h0041_FFFF, "R8 evsel keeps defined bits");
    wr(12'h188, 64'd0);

    // R9 unmapped access
    rd(12'h185, d, e); chk(d, 64'd0, "R9 unmapped read zero"); chk(64'(e), 64'd1, "R9 error strobe");
    @(negedge clk); chk(64'(reg_err), 64'd0, "R9 error lasts one cycle");
    wr(12'h0C5, 64'h55);
    @(negedge clk); chk(64'(reg_err), 64'd0, "R9 error single pulse after write");
    wr(12'h18A, 64'h0041_FF00);
    rd(12'h0C1, d, e); chk(d, 64'd100, "R9 unmapped write leaves counter0");
    rd(12'h189, d, e); chk(d, 64'd0, "R9 unmapped write leaves evsel3");
    rd(12'h38F, d, e); chk(d, G_RST, "R9 unmapped write leaves global");

    // R10 read path
    wr(12'h0C2, 64'h0000_1234_5678_9ABC);
    usr_rd_allow = 1'b0; priv_lvl = 2'd0;
    prd(1, lo, hi, f, v);
    chk(64'(lo), 64'h5678_9ABC, "R10 low half"); chk(64'(hi), 64'h1234, "R10 high half");
    chk(64'(v), 64'd1, "R10 valid"); chk(64'(f), 64'd0, "R10 level0 allowed");
    priv_lvl = 2'd3;
    prd(1, lo, hi, f, v);
    chk(64'(f), 64'd1, "R10 level3 fault"); chk({hi, lo}, 64'd0, "R10 fault data zero");
    usr_rd_allow = 1'b1;
    prd(1, lo, hi, f, v);
    chk(64'(f), 64'd0, "R10 level3 allowed"); chk({hi, lo}, 64'h0000_1234_5678_9ABC, "R10 level3 data");

    // random rounds R2 R3 R4 R5 R10
    for (int r = 0; r < 10; r++) begin
      for (int i = 0; i < NC; i++) begin
        logic [7:0] code;
        int pick = int'($urandom_range(0, 3));
        code = (pick == 0) ? 8'h24 : (pick == 1) ? 8'h10 : (pick == 2) ? 8'h3F : 8'h55;
        wr(12'(12'h186 + i), {41'b0, 1'($urandom_range(0, 4) != 0), 5'b0, 1'($urandom),
                              8'($urandom), code});
        if (r % 3 == 0) wr(12'(12'h0C1 + i), 64'd0);
      end
      wr(12'h38F, 64'($urandom) | (64'($urandom) << 32));
      for (int c = 0; c < 150; c++) begin
        @(negedge clk);
        evt_pulse = {32'($urandom), 32'($urandom)};
        for (int k = 0; k < NL; k++) evt_qual[k*8 +: 8] = 8'($urandom);
        priv_lvl = ($urandom_range(0, 1) != 0) ? 2'd3 : 2'(($urandom_range(0, 2)));
      end
      @(negedge clk); evt_pulse = '0; evt_qual = '0; priv_lvl = 2'd0;
      for (int i = 0; i < NC; i++) begin
        rd(12'(12'h0C1 + i), d, e); chk(d, 64'(m_cnt[i]), "R3 random counter value");
        rd(12'(12'h186 + i), d, e); chk(d, m_sel[i], "R5 random evsel readback");
        prd(i, lo, hi, f, v); chk({hi, lo}, 64'(m_cnt[i]), "R10 random read path");
      end
      rd(12'h38F, d, e); chk(d, m_g, "R2 random global readback");
    end

    summary();
    $finish;
  end
endmodule